// File: doc/BRIEF.md
# SDRAM Refresh and Self-Refresh Scheduler

This block keeps a DDR SDRAM refreshed. A programmable interval counter adds one owed refresh each time it wraps. The interval is set so that 8192 refreshes fit within 64 ms, which gives about 7.8 µs per refresh. Owed refreshes are held in a saturating counter. When the memory controller reports an idle bus, or when the counter is full, the scheduler runs its sequence: a precharge-all strobe, a wait of tRP clocks, an auto-refresh strobe, and then a wait of tRFC clocks. The block stays busy from the precharge-all until that wait ends.

The scheduler also handles self refresh. A request is taken only when no refresh is owed. The block then precharges all banks, waits tRP, and issues the refresh command with the clock enable driven low. The clock enable stays low while the request is held. When the request drops, the clock enable rises and three things happen: one refresh is owed and forced, the interval counter restarts, and reads are blocked for a fixed DLL relock window.

Top module: `refresh_sched`

## Requirements
- R1: During reset the outputs are: cke high, busy low, all three command strobes low, force_pri low, rd_ok high.
- R2: One refresh becomes owed each `interval_clks` clocks. After k clocks out of reset, floor(k/interval_clks) refreshes are owed. A refresh owed on a clock is visible on that clock, and its cmd_pall follows one clock later if the bus is idle.
- R3: The owed count saturates at 8. While it is 8, force_pri is high and a sequence starts on the next clock whatever bus_idle says.
- R4: A refresh sequence starts only when a refresh is owed and either bus_idle is high or force_pri is high.
- R5: cmd_ref, or cmd_sre in the self-refresh case, comes exactly max(trp_clks,1) clocks after cmd_pall.
- R6: busy is high on the cmd_pall clock. It falls exactly max(trfc_clks,1) clocks after cmd_ref.
- R7: A self-refresh request is taken only when the scheduler is idle, no refresh is owed and bus_idle is high. An owed refresh is served first. cmd_sre comes with cke low on the same clock.
- R8: cke stays low for as long as sr_req is held. It rises one clock after sr_req is seen low. Every cke level lasts at least one clock.
- R9: On the clock cke rises, force_pri is high. The forced refresh issues cmd_pall on the next clock.
- R10: rd_ok is low from the self-refresh entry until 200 clocks after cke rises. It is also low whenever busy is high.
- R11: No refresh becomes owed during self refresh. The interval restarts at exit, so the next owed refresh appears interval_clks clocks after cke rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| interval_clks | input | INT_W | Clocks per average refresh interval |
| trp_clks | input | TIME_W | Precharge-to-refresh wait (0 is taken as 1) |
| trfc_clks | input | TIME_W | Refresh cycle wait (0 is taken as 1) |
| bus_idle | input | 1 | Controller grants the command bus |
| sr_req | input | 1 | Level request to stay in self refresh |
| cmd_pall | output | 1 | Precharge-all strobe |
| cmd_ref | output | 1 | Auto-refresh strobe |
| cmd_sre | output | 1 | Self-refresh entry strobe |
| cke | output | 1 | Clock enable to the memory |
| busy | output | 1 | Scheduler owns the command bus |
| rd_ok | output | 1 | Reads are allowed |
| force_pri | output | 1 | Refresh takes priority over other traffic |

## Verification
The assertions assume the timing inputs do not change while busy is high. They also assume the interval is longer than one complete refresh sequence, so the counter can drain whenever the bus is granted. The stimulus changes the interval, tRP and tRFC only while reset is held. It keeps random intervals well above the longest sequence the random tRP and tRFC can build. Only bus_idle is drawn at random on every clock, and sr_req is held as a clean level across whole self-refresh stays.

// File: rtl/refsched_pkg.sv
package refsched_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PALL = 3'd1,
    ST_RP   = 3'd2,
    ST_REF  = 3'd3,
    ST_RFC  = 3'd4,
    ST_SRE  = 3'd5,
    ST_SR   = 3'd6
  } seq_st_e;

  // Remaining wait after a strobe cycle for a span of clks (0 and 1 act as 1).
  function automatic int span_last(input int clks);
    if (clks <= 1) return 0;
    return clks - 1;
  endfunction

  // Owed-refresh count after one clock: service first, then saturating add.
  function automatic int pend_next(input int cur, input bit inc, input bit dec, input int cap);
    int n;
    n = cur;
    if (dec && n > 0) n = n - 1;
    if (inc && n < cap) n = n + 1;
    return n;
  endfunction

endpackage

// File: rtl/refsched_interval.sv
module refsched_interval
  import refsched_pkg::*;
#(
  parameter int INT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [INT_W-1:0] period,
  input  logic             hold,
  output logic             tick
);

  logic [INT_W-1:0] cnt;
  logic [INT_W-1:0] last;

  always_comb last = INT_W'(span_last(int'(period)));

  assign tick = !hold && (cnt >= last);

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (hold || tick) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/refsched_pending.sv
module refsched_pending
  import refsched_pkg::*;
#(
  parameter int CAP = 8,
  localparam int PW = $clog2(CAP + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  input  logic load_one,
  output logic any,
  output logic full
);

  logic [PW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (load_one) cnt <= PW'(1);
    else               cnt <= PW'(pend_next(int'(cnt), inc, dec, CAP));
  end

  assign any  = (cnt != '0);
  assign full = (cnt == PW'(CAP));

  AST_PEND_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (full && inc && !dec && !load_one) |=> full); // R3

endmodule

// File: rtl/refsched_relock.sv
module refsched_relock #(
  parameter int CYCLES = 200,
  localparam int RW = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic done
);

  logic [RW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= RW'(CYCLES);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

  AST_RELOCK_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done); // R10

endmodule

// File: rtl/refsched_seq.sv
module refsched_seq
  import refsched_pkg::*;
#(
  parameter int TIME_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] trp,
  input  logic [TIME_W-1:0] trfc,
  input  logic              bus_idle,
  input  logic              sr_req,
  input  logic              pend_any,
  input  logic              pend_full,
  output logic              cmd_pall,
  output logic              cmd_ref,
  output logic              cmd_sre,
  output logic              cke,
  output logic              busy,
  output logic              force_pri,
  output logic              sr_hold,
  output logic              sr_exit
);

  seq_st_e           st, st_n;
  logic              for_sr;
  logic              post_sr;
  logic [TIME_W-1:0] wcnt;
  logic              ref_go, sr_go;

  assign force_pri = pend_full || post_sr;
  assign ref_go    = (st == ST_IDLE) && pend_any && (bus_idle || force_pri);
  assign sr_go     = (st == ST_IDLE) && !ref_go && sr_req && !pend_any && bus_idle && !post_sr;
  assign sr_exit   = (st == ST_SR) && !sr_req;

  always_comb begin
    st_n = st;
    case (st)
      ST_IDLE: if (ref_go || sr_go) st_n = ST_PALL;
      ST_PALL: st_n = (int'(trp) <= 1) ? (for_sr ? ST_SRE : ST_REF) : ST_RP;
      ST_RP:   if (wcnt <= 1) st_n = for_sr ? ST_SRE : ST_REF;
      ST_REF:  st_n = (int'(trfc) <= 1) ? ST_IDLE : ST_RFC;
      ST_RFC:  if (wcnt <= 1) st_n = ST_IDLE;
      ST_SRE:  st_n = ST_SR;
      ST_SR:   if (!sr_req) st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      for_sr  <= 1'b0;
      post_sr <= 1'b0;
      wcnt    <= '0;
    end else begin
      st <= st_n;
      if (st == ST_IDLE) for_sr <= sr_go;
      case (st)
        ST_PALL:      wcnt <= TIME_W'(span_last(int'(trp)));
        ST_REF:       wcnt <= TIME_W'(span_last(int'(trfc)));
        ST_RP, ST_RFC: wcnt <= wcnt - 1'b1;
        default:      wcnt <= wcnt;
      endcase
      if (sr_exit)      post_sr <= 1'b1;
      else if (cmd_ref) post_sr <= 1'b0;
    end
  end

  assign cmd_pall = (st == ST_PALL);
  assign cmd_ref  = (st == ST_REF);
  assign cmd_sre  = (st == ST_SRE);
  assign cke      = !((st == ST_SRE) || (st == ST_SR));
  assign busy     = (st != ST_IDLE);
  assign sr_hold  = sr_go || (st == ST_SRE) || (st == ST_SR) ||
                    (for_sr && ((st == ST_PALL) || (st == ST_RP)));

  AST_FORCE_START: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_IDLE) && pend_full) |=> cmd_pall); // R3
  AST_CKE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |=> !cke); // R8
  AST_EXIT_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    sr_exit |=> (force_pri && cke)); // R9

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched #(
  parameter int INT_W  = 16,
  parameter int TIME_W = 8,
  parameter int PEND_CAP = 8,
  parameter int RELOCK_CLKS = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [INT_W-1:0]  interval_clks,
  input  logic [TIME_W-1:0] trp_clks,
  input  logic [TIME_W-1:0] trfc_clks,
  input  logic              bus_idle,
  input  logic              sr_req,
  output logic              cmd_pall,
  output logic              cmd_ref,
  output logic              cmd_sre,
  output logic              cke,
  output logic              busy,
  output logic              rd_ok,
  output logic              force_pri
);

  logic tick, pend_any, pend_full, sr_hold, sr_exit, relock_done;

  refsched_interval #(.INT_W(INT_W)) u_interval (
    .clk(clk), .rst_n(rst_n), .period(interval_clks), .hold(sr_hold), .tick(tick)
  );

  refsched_pending #(.CAP(PEND_CAP)) u_pending (
    .clk(clk), .rst_n(rst_n), .inc(tick), .dec(cmd_ref), .load_one(sr_exit),
    .any(pend_any), .full(pend_full)
  );

  refsched_seq #(.TIME_W(TIME_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .trp(trp_clks), .trfc(trfc_clks),
    .bus_idle(bus_idle), .sr_req(sr_req), .pend_any(pend_any), .pend_full(pend_full),
    .cmd_pall(cmd_pall), .cmd_ref(cmd_ref), .cmd_sre(cmd_sre), .cke(cke),
    .busy(busy), .force_pri(force_pri), .sr_hold(sr_hold), .sr_exit(sr_exit)
  );

  refsched_relock #(.CYCLES(RELOCK_CLKS)) u_relock (
    .clk(clk), .rst_n(rst_n), .start(sr_exit), .done(relock_done)
  );

  assign rd_ok = !busy && relock_done;

  AST_SR_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_sre |-> !pend_any); // R7
  AST_NO_TICK_SR: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> !tick); // R11
  AST_RELOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> !rd_ok); // R10

endmodule

// File: tb/refresh_sched_tb.sv
module refresh_sched_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [15:0] period;
  logic [7:0]  trp, trfc;
  logic        bus_idle, sr_req;
  logic        cmd_pall, cmd_ref, cmd_sre, cke, busy, rd_ok, force_pri;

  refresh_sched u_dut (
    .clk(clk), .rst_n(rst_n), .interval_clks(period), .trp_clks(trp), .trfc_clks(trfc),
    .bus_idle(bus_idle), .sr_req(sr_req), .cmd_pall(cmd_pall), .cmd_ref(cmd_ref),
    .cmd_sre(cmd_sre), .cke(cke), .busy(busy), .rd_ok(rd_ok), .force_pri(force_pri)
  );

  int nchk = 0, nfail = 0;
  int cyc;
  int last_pall, last_ref, rise_cyc, npall, nref, nsre, first_pall, first_ref, first_sre;
  bit pall_open, ref_open, prev_cke;
  bit finished = 0;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  function automatic int eff(input int v);
    return (v <= 1) ? 1 : v;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  // Event monitor: sequence spacing and strobe coupling.
  always @(negedge clk) begin
    if (rst_n) begin
      if (cmd_pall) begin
        chk(busy && !rd_ok, "R6/R10 busy at pall", {busy, rd_ok}, 2);
        last_pall = cyc; pall_open = 1; npall++;
        if (first_pall < 0) first_pall = cyc;
      end
      if (cmd_ref || cmd_sre) begin
        chk(pall_open && (cyc - last_pall == eff(int'(trp))), "R5 pall-to-ref",
            cyc - last_pall, eff(int'(trp)));
        pall_open = 0;
      end
      if (cmd_sre) begin
        chk(!cke, "R7 cke low with sre", cke, 0);
        nsre++;
        if (first_sre < 0) first_sre = cyc;
      end
      if (cmd_ref) begin
        nref++; last_ref = cyc; ref_open = 1;
        if (first_ref < 0) first_ref = cyc;
      end else if (ref_open && !busy) begin
        chk(cyc - last_ref == eff(int'(trfc)), "R6 ref-to-idle", cyc - last_ref, eff(int'(trfc)));
        ref_open = 0;
      end
      if (cke && !prev_cke) rise_cyc = cyc;
      prev_cke = cke;
    end
  end

  task automatic do_reset(input int n, input int p, input int f, input bit idle);
    rst_n = 0; period = 16'(n); trp = 8'(p); trfc = 8'(f); bus_idle = idle; sr_req = 0;
    repeat (3) @(negedge clk);
    last_pall = 0; last_ref = 0; rise_cyc = -1; npall = 0; nref = 0; nsre = 0;
    first_pall = -1; first_ref = -1; first_sre = -1;
    pall_open = 0; ref_open = 0; prev_cke = 1;
    rst_n = 1;
  endtask

  task automatic wait_cyc(input int c);
    do @(negedge clk); while (cyc < c);
    #1;
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nchk++; nfail++;
    $display("FAIL watchdog expired: actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));

    // R1: reset state
    rst_n = 0; period = 16'd10; trp = 8'd2; trfc = 8'd2; bus_idle = 0; sr_req = 0;
    repeat (2) @(negedge clk);
    #1;
    chk(cke && !busy && !cmd_pall && !cmd_ref && !cmd_sre && rd_ok && !force_pri,
        "R1 reset outputs", {cke, busy, cmd_pall, cmd_ref, cmd_sre, rd_ok, force_pri}, 7'b1000010);

    // R2/R3/R4: accumulate with bus busy, forced start at the cap, then drain
    do_reset(10, 2, 2, 0);
    wait_cyc(79);
    chk(!force_pri, "R3 not forced below cap", force_pri, 0);
    chk(npall == 0, "R4 no start while bus busy", npall, 0);
    wait_cyc(80);
    chk(force_pri, "R3 forced at cap of 8", force_pri, 1);
    wait_cyc(81);
    chk(first_pall == 81, "R3 forced start cycle", first_pall, 81);
    wait_cyc(200);
    bus_idle = 1;
    wait_cyc(400);
    chk(nref == 39, "R2 refreshes per interval", nref, 39);

    // R7/R8/R9/R10/R11: self-refresh entry, stay, exit
    do_reset(30, 2, 5, 1);
    wait_cyc(5);
    sr_req = 1;
    wait_cyc(8);
    chk(first_pall == 6, "R7 entry precharge", first_pall, 6);
    chk(first_sre == 8, "R7 entry strobe", first_sre, 8);
    wait_cyc(30);
    chk(!rd_ok, "R10 no read in self refresh", rd_ok, 0);
    wait_cyc(59);
    chk(!cke, "R8 cke held low", cke, 0);
    chk(npall == 1 && nref == 0, "R11 nothing owed in self refresh", npall, 1);
    wait_cyc(60);
    sr_req = 0;
    wait_cyc(61);
    chk(rise_cyc == 61, "R8 cke rise after release", rise_cyc, 61);
    chk(force_pri, "R9 forced after exit", force_pri, 1);
    chk(!rd_ok, "R10 blocked at exit", rd_ok, 0);
    wait_cyc(62);
    chk(npall == 2, "R9 forced precharge next cycle", npall, 2);
    wait_cyc(91);
    chk(npall == 2, "R11 interval restarted at exit", npall, 2);
    wait_cyc(92);
    chk(npall == 3, "R11 R2 first tick after exit", npall, 3);
    wait_cyc(260);
    chk(!rd_ok, "R10 relock window", rd_ok, 0);
    wait_cyc(261);
    chk(rd_ok, "R10 reads allowed after relock", rd_ok, 1);

    // R7: request with a refresh owed is served after the refresh
    do_reset(20, 1, 1, 0);
    wait_cyc(25);
    sr_req = 1; bus_idle = 1;
    wait_cyc(40);
    chk(first_ref == 27, "R7 owed refresh first", first_ref, 27);
    chk(first_sre == 30, "R7 entry after refresh", first_sre, 30);
    wait_cyc(45);
    sr_req = 0;
    wait_cyc(60);

    // R2/R5/R6: random bus grants with random timing per round
    for (int r = 0; r < 4; r++) begin
      int n, k, exp_n;
      n = 40 + int'($urandom % 30);
      do_reset(n, int'($urandom % 5), int'($urandom % 12), 0);
      for (int i = 0; i < 1500; i++) begin
        @(negedge clk); #1;
        bus_idle = $urandom % 2;
      end
      bus_idle = 1;
      wait_cyc(cyc + 100);
      k = cyc;
      exp_n = k / n;
      chk(nref == exp_n || nref == exp_n - 1, "R2 random rate", nref, exp_n);
    end

    finish_run();
  end

endmodule